// File: doc/BRIEF.md
# Gated Echo Time-of-Flight Capture

This block measures how long an ultrasonic burst takes to reach the receiver. It starts counting when a transmit strobe arrives. It then watches two synchronous receive flags. One says the echo envelope is above its threshold. The other marks a comparator crossing. The block keeps the first crossing that is both inside a programmable acceptance window and under a qualified envelope. Before the window there is a blanking interval. During blanking all receive activity is thrown away, so transmit leakage can never be taken for an echo.

Every shot also produces evidence that a later stage can use to judge the measurement:
- how many qualified crossings landed in the window;
- how many crossings were rejected because they fell outside it;
- how many separate envelope bursts appeared inside it, which hints at multipath.

Upstream and downstream shots are tagged with a direction bit. Both are stamped against one free-running time base, so the difference between directions cancels drift that is common to both. Blanking length, window start and window length are given in time-base ticks, where one tick is one clock cycle. They are captured at transmit and held for the whole shot.

Top module: `echo_tof_capture`

## Requirements
- R1: After reset every result output, the done pulse and the overrun flag are 0.
- R2: With the transmit strobe accepted in cycle 0, receive activity in relative cycles 1 through the blanking length has no effect on any result field: crossings, envelope and peaks are all ignored there.
- R3: The acceptance window covers relative cycles win_start to win_start+win_len-1, excluding blanked cycles. res_tof reports the relative cycle of the first crossing in the window while env_ok is high, and res_valid is 1 then.
- R4: A crossing after blanking that is outside the window, or inside it with env_ok low, increments res_oow_hits and is never used as the timestamp.
- R5: res_win_hits counts qualified crossings. When it is 0, res_valid is 0 and res_no_echo is 1; otherwise res_no_echo is 0.
- R6: res_peaks counts the cycles in which env_ok is high inside the window and was not high inside the window in the previous cycle. A burst already high at the first window cycle counts as one peak.
- R7: The shot closes in relative cycle max(win_start+win_len-1, 1). done is a single-cycle pulse in the following cycle, and all result fields update in that same cycle and hold until the next done.
- R8: The blanking and window settings are sampled only in the transmit cycle. Changing them during a shot has no effect on that shot.
- R9: A transmit strobe while a shot is active, including its closing cycle, is ignored: the running shot's results are unchanged, no new shot starts, and the sticky overrun output goes to 1 and stays there.
- R10: res_tx_time is the shared time-base value in the accepted transmit cycle, which makes the difference between two shots equal to the number of cycles between their strobes, modulo 2^TBW. res_dir echoes the direction bit captured at transmit.
- R11: res_win_hits, res_oow_hits and res_peaks saturate at 2^CW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time-base tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Transmit strobe, one cycle |
| tx_dir | input | 1 | Shot direction, 0 upstream, 1 downstream |
| cfg_blank | input | CFW | Blanking length in ticks |
| cfg_win_start | input | CFW | Window start, relative tick |
| cfg_win_len | input | CFW | Window length in ticks |
| env_ok | input | 1 | Envelope above threshold |
| rx_cross | input | 1 | Comparator crossing event |
| done | output | 1 | One-cycle result strobe |
| res_valid | output | 1 | A qualified crossing was captured |
| res_no_echo | output | 1 | No qualified crossing in the window |
| res_dir | output | 1 | Direction of the reported shot |
| res_tof | output | CFW+2 | Ticks from transmit to the first qualified crossing |
| res_win_hits | output | CW | Qualified crossings in the window |
| res_oow_hits | output | CW | Rejected crossings |
| res_peaks | output | CW | Envelope bursts inside the window |
| res_tx_time | output | TBW | Time-base value at transmit |
| overrun | output | 1 | Sticky: a strobe arrived during a shot |

## Verification
Two things can land in the same cycle. A new transmit strobe can arrive in the shot's closing cycle, while the last window sample is still being classified and the results are latched. The bench forces this by pulsing tx_start exactly one cycle before the expected done. It then judges the outcome in two ways: the closing shot's results must match the reference model, and no further done may appear during a long idle watch. A second overlap is a crossing in the very first window cycle while the envelope rises. The random shots produce this often, and the model scores it as both a peak and a hit.

// File: rtl/tof_pkg.sv
package tof_pkg;

  // Per-cycle classification of receive activity during a shot.
  typedef struct packed {
    logic hit;    // qualified crossing inside the window
    logic stray;  // crossing after blanking that was rejected
    logic peak;   // envelope newly qualified inside the window
  } rx_evt_t;

  localparam int EVT_N = 3;

endpackage

// File: rtl/tof_timebase.sv
module tof_timebase #(
  parameter int TBW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TBW-1:0] tb_now
);

  logic [TBW-1:0] tb_q;
  logic [TBW-1:0] tb_d;

  always_comb begin
    tb_d = tb_q + TBW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_d;
  end

  assign tb_now = tb_q;

endmodule

// File: rtl/tof_shot_seq.sv
module tof_shot_seq #(
  parameter int CFW = 8,
  parameter int EW  = CFW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_start,
  input  logic           tx_dir,
  input  logic [CFW-1:0] cfg_blank,
  input  logic [CFW-1:0] cfg_win_start,
  input  logic [CFW-1:0] cfg_win_len,
  output logic           active,
  output logic [EW-1:0]  elap,
  output logic           accept,
  output logic           closing,
  output logic [CFW-1:0] blank_q,
  output logic [CFW-1:0] wstart_q,
  output logic [EW-1:0]  wend_q,
  output logic           dir_q,
  output logic           overrun
);

  logic          active_q, active_d;
  logic [EW-1:0] elap_q, elap_d;
  logic          ovr_q, ovr_d;
  logic [EW-1:0] wend_calc;
  logic [EW:0]   elap_inc;

  always_comb begin
    accept    = tx_start & ~active_q;
    wend_calc = EW'(cfg_win_start) + EW'(cfg_win_len);
    elap_inc  = {1'b0, elap_q} + (EW+1)'(1);
    closing   = active_q & (elap_inc >= {1'b0, wend_q});
    ovr_d     = ovr_q | (tx_start & active_q);
    active_d  = active_q;
    elap_d    = elap_q;
    if (accept) begin
      active_d = 1'b1;
      elap_d   = EW'(1);
    end else if (closing) begin
      active_d = 1'b0;
    end else if (active_q) begin
      elap_d = elap_inc[EW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      elap_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      elap_q   <= elap_d;
      ovr_q    <= ovr_d;
    end
  end

  // Shot settings, captured only when a strobe is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q  <= '0;
      wstart_q <= '0;
      wend_q   <= '0;
      dir_q    <= 1'b0;
    end else if (accept) begin
      blank_q  <= cfg_blank;
      wstart_q <= cfg_win_start;
      wend_q   <= wend_calc;
      dir_q    <= tx_dir;
    end
  end

  assign active  = active_q;
  assign elap    = elap_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/tof_rx_classify.sv
module tof_rx_classify
  import tof_pkg::*;
#(
  parameter int CFW = 8,
  parameter int EW  = CFW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           accept,
  input  logic [EW-1:0]  elap,
  input  logic [CFW-1:0] blank_q,
  input  logic [CFW-1:0] wstart_q,
  input  logic [EW-1:0]  wend_q,
  input  logic           env_ok,
  input  logic           rx_cross,
  output rx_evt_t        evt
);

  logic blanked, in_win, qual, qual_prev_q, qual_prev_d, listen;

  always_comb begin
    blanked   = elap <= EW'(blank_q);
    listen    = active & ~blanked;
    in_win    = listen & (elap >= EW'(wstart_q)) & (elap < wend_q);
    qual      = in_win & env_ok;
    evt.hit   = qual & rx_cross;
    evt.stray = listen & rx_cross & ~qual;
    evt.peak  = qual & ~qual_prev_q;
    qual_prev_d = qual_prev_q;
    if (accept)      qual_prev_d = 1'b0;
    else if (active) qual_prev_d = qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_prev_q <= 1'b0;
    else        qual_prev_q <= qual_prev_d;
  end

endmodule

// File: rtl/tof_sat_cnt.sv
module tof_sat_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_d,
  output logic [CW-1:0] cnt_q
);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (inc && ~&cnt_q)   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tof_evidence.sv
module tof_evidence
  import tof_pkg::*;
#(
  parameter int CFW = 8,
  parameter int CW  = 4,
  parameter int TBW = 16,
  parameter int EW  = CFW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           closing,
  input  logic [EW-1:0]  elap,
  input  rx_evt_t        evt,
  input  logic           dir_q,
  input  logic [TBW-1:0] tb_now,
  output logic           done,
  output logic           res_valid,
  output logic           res_no_echo,
  output logic           res_dir,
  output logic [EW-1:0]  res_tof,
  output logic [CW-1:0]  res_win_hits,
  output logic [CW-1:0]  res_oow_hits,
  output logic [CW-1:0]  res_peaks,
  output logic [TBW-1:0] res_tx_time
);

  logic [EVT_N-1:0]  incs;
  logic [CW-1:0]     cnt_d [EVT_N];
  logic [CW-1:0]     cnt_q [EVT_N];

  assign incs = {evt.peak, evt.stray, evt.hit};

  for (genvar i = 0; i < EVT_N; i++) begin : g_cnt
    tof_sat_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (incs[i]),
      .cnt_d (cnt_d[i]),
      .cnt_q (cnt_q[i])
    );
  end

  logic           got_q, got_d;
  logic [EW-1:0]  tof_q, tof_d;
  logic [TBW-1:0] tx_q, tx_d;
  logic           any_hit;
  logic [EW-1:0]  tof_out;

  always_comb begin
    any_hit = got_q | evt.hit;
    got_d   = accept ? 1'b0 : any_hit;
    tof_d   = (evt.hit && !got_q) ? elap : tof_q;
    tx_d    = accept ? tb_now : tx_q;
    tof_out = any_hit ? tof_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= 1'b0;
      tof_q <= '0;
      tx_q  <= '0;
    end else begin
      got_q <= got_d;
      tof_q <= tof_d;
      tx_q  <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= closing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_no_echo  <= 1'b0;
      res_dir      <= 1'b0;
      res_tof      <= '0;
      res_win_hits <= '0;
      res_oow_hits <= '0;
      res_peaks    <= '0;
      res_tx_time  <= '0;
    end else if (closing) begin
      res_valid    <= any_hit;
      res_no_echo  <= ~any_hit;
      res_dir      <= dir_q;
      res_tof      <= tof_out;
      res_win_hits <= cnt_d[0];
      res_oow_hits <= cnt_d[1];
      res_peaks    <= cnt_d[2];
      res_tx_time  <= tx_q;
    end
  end

endmodule

// File: rtl/echo_tof_capture.sv
module echo_tof_capture
  import tof_pkg::*;
#(
  parameter int CFW = 8,
  parameter int CW  = 4,
  parameter int TBW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_start,
  input  logic           tx_dir,
  input  logic [CFW-1:0] cfg_blank,
  input  logic [CFW-1:0] cfg_win_start,
  input  logic [CFW-1:0] cfg_win_len,
  input  logic           env_ok,
  input  logic           rx_cross,
  output logic           done,
  output logic           res_valid,
  output logic           res_no_echo,
  output logic           res_dir,
  output logic [CFW+1:0] res_tof,
  output logic [CW-1:0]  res_win_hits,
  output logic [CW-1:0]  res_oow_hits,
  output logic [CW-1:0]  res_peaks,
  output logic [TBW-1:0] res_tx_time,
  output logic           overrun
);

  localparam int EW = CFW + 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [TBW-1:0] tb_now;
  logic           shot_active, accept, closing, dir_q;
  logic [EW-1:0]  elap, wend_q;
  logic [CFW-1:0] blank_q, wstart_q;
  rx_evt_t        evt;

  tof_timebase #(.TBW(TBW)) u_tb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tb_now (tb_now)
  );

  tof_shot_seq #(.CFW(CFW), .EW(EW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .tx_start      (tx_start),
    .tx_dir        (tx_dir),
    .cfg_blank     (cfg_blank),
    .cfg_win_start (cfg_win_start),
    .cfg_win_len   (cfg_win_len),
    .active        (shot_active),
    .elap          (elap),
    .accept        (accept),
    .closing       (closing),
    .blank_q       (blank_q),
    .wstart_q      (wstart_q),
    .wend_q        (wend_q),
    .dir_q         (dir_q),
    .overrun       (overrun)
  );

  tof_rx_classify #(.CFW(CFW), .EW(EW)) u_cls (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .active   (shot_active),
    .accept   (accept),
    .elap     (elap),
    .blank_q  (blank_q),
    .wstart_q (wstart_q),
    .wend_q   (wend_q),
    .env_ok   (env_ok),
    .rx_cross (rx_cross),
    .evt      (evt)
  );

  tof_evidence #(.CFW(CFW), .CW(CW), .TBW(TBW), .EW(EW)) u_evd (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .accept       (accept),
    .closing      (closing),
    .elap         (elap),
    .evt          (evt),
    .dir_q        (dir_q),
    .tb_now       (tb_now),
    .done         (done),
    .res_valid    (res_valid),
    .res_no_echo  (res_no_echo),
    .res_dir      (res_dir),
    .res_tof      (res_tof),
    .res_win_hits (res_win_hits),
    .res_oow_hits (res_oow_hits),
    .res_peaks    (res_peaks),
    .res_tx_time  (res_tx_time)
  );

endmodule

// File: rtl/tof_capture_chk.sv
module tof_capture_chk #(
  parameter int CFW = 8,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tx_start,
  input logic           active,
  input logic           done,
  input logic           res_valid,
  input logic           res_no_echo,
  input logic [CFW+1:0] res_tof,
  input logic [CW-1:0]  res_win_hits,
  input logic           overrun
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_tof) && $stable(res_win_hits) && $stable(res_valid)));

  // R5
  no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((res_no_echo == (res_win_hits == '0)) && (res_valid != res_no_echo)));

  // R3
  tof_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_valid) |-> (res_tof != '0));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && active) |=> overrun);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind echo_tof_capture tof_capture_chk #(.CFW(CFW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_start     (tx_start),
  .active       (shot_active),
  .done         (done),
  .res_valid    (res_valid),
  .res_no_echo  (res_no_echo),
  .res_tof      (res_tof),
  .res_win_hits (res_win_hits),
  .overrun      (overrun)
);

// File: tb/echo_tof_capture_test.sv
module echo_tof_capture_test;

  localparam int CLK_P = 10;
  localparam int CFW = 8;
  localparam int CW  = 4;
  localparam int TBW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tx_start, tx_dir, env_ok, rx_cross;
  logic [CFW-1:0] cfg_blank, cfg_win_start, cfg_win_len;
  logic           done, res_valid, res_no_echo, res_dir, overrun;
  logic [CFW+1:0] res_tof;
  logic [CW-1:0]  res_win_hits, res_oow_hits, res_peaks;
  logic [TBW-1:0] res_tx_time;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  finished = 0;
  bit  env_a   [256];
  bit  cross_a [256];
  int  prev_tx_cyc = 0;
  int  prev_res_tx = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  echo_tof_capture #(.CFW(CFW), .CW(CW), .TBW(TBW)) uut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_dir(tx_dir),
    .cfg_blank(cfg_blank), .cfg_win_start(cfg_win_start), .cfg_win_len(cfg_win_len),
    .env_ok(env_ok), .rx_cross(rx_cross), .done(done), .res_valid(res_valid),
    .res_no_echo(res_no_echo), .res_dir(res_dir), .res_tof(res_tof),
    .res_win_hits(res_win_hits), .res_oow_hits(res_oow_hits), .res_peaks(res_peaks),
    .res_tx_time(res_tx_time), .overrun(overrun)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_arrays();
    for (int t = 0; t < 256; t++) begin
      env_a[t] = 0;
      cross_a[t] = 0;
    end
  endtask

  task automatic fill_random();
    bit e = 0;
    for (int t = 0; t < 256; t++) begin
      if ($urandom % 5 == 0) e = ~e;
      env_a[t]   = e;
      cross_a[t] = ($urandom % 4 == 0);
    end
  endtask

  // Runs one shot; inj > 0 pulses tx_start again in that relative cycle.
  task automatic run_shot(int bl, int ws, int wl, bit dir, int inj, bit chk_delta);
    int close_t, d, hits, stray, peaks, tof, tx_cyc;
    bit prevq, qual, blanked, inwin, early_done;
    close_t = (ws + wl - 1 >= 1) ? ws + wl - 1 : 1;
    d = close_t + 1;
    hits = 0; stray = 0; peaks = 0; tof = 0; prevq = 0;
    for (int t = 1; t <= close_t; t++) begin
      blanked = (t <= bl);
      inwin   = !blanked && (t >= ws) && (t < ws + wl);
      qual    = inwin && env_a[t];
      if (!blanked && cross_a[t]) begin
        if (qual) begin
          if (hits == 0) tof = t;
          if (hits < CMAX) hits++;
        end else if (stray < CMAX) stray++;
      end
      if (qual && !prevq && peaks < CMAX) peaks++;
      prevq = qual;
    end
    @(negedge clk);
    tx_start = 1; tx_dir = dir;
    cfg_blank = CFW'(bl); cfg_win_start = CFW'(ws); cfg_win_len = CFW'(wl);
    env_ok = 0; rx_cross = 0;
    tx_cyc = cyc;
    early_done = 0;
    for (int t = 1; t <= d; t++) begin
      @(negedge clk);
      tx_start = (t == inj);
      // R8: settings scrambled during the shot must not matter
      cfg_blank = CFW'($urandom); cfg_win_start = CFW'($urandom); cfg_win_len = CFW'($urandom);
      if (t < d) begin
        if (done) early_done = 1;
        env_ok = env_a[t]; rx_cross = cross_a[t];
      end else begin
        env_ok = 0; rx_cross = 0;
        chk("R7 done at close+1", done, 1);
        chk("R7 no early done", early_done, 0);
        chk("R3 tof", res_tof, tof);
        chk("R3 valid", res_valid, hits > 0);
        chk("R5 no_echo", res_no_echo, hits == 0);
        chk("R5 R11 window hits", res_win_hits, hits);
        chk("R4 R11 stray hits", res_oow_hits, stray);
        chk("R6 R11 peaks", res_peaks, peaks);
        chk("R10 direction", res_dir, dir);
        if (chk_delta)
          chk("R10 shared time base delta", (int'(res_tx_time) - prev_res_tx) & 16'hFFFF,
              (tx_cyc - prev_tx_cyc) & 16'hFFFF);
        prev_tx_cyc = tx_cyc;
        prev_res_tx = int'(res_tx_time);
      end
    end
    tx_start = 0;
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
  endtask

  initial begin
    int nd;
    void'($urandom(32'h5EED_7A1C));
    rst_n = 0; tx_start = 0; tx_dir = 0; env_ok = 0; rx_cross = 0;
    cfg_blank = 0; cfg_win_start = 0; cfg_win_len = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 valid", res_valid, 0);
    chk("R1 tof", res_tof, 0);
    chk("R1 counters", {res_win_hits, res_oow_hits, res_peaks}, 0);
    chk("R1 overrun", overrun, 0);

    // R3 R4 R6 directed: window 5..10, blanking 1..3
    clear_arrays();
    cross_a[2] = 1; env_a[2] = 1;        // blanked
    cross_a[4] = 1;                       // before window
    cross_a[5] = 1;                       // window, envelope low
    env_a[6] = 1; env_a[7] = 1; env_a[8] = 1; env_a[10] = 1;
    cross_a[7] = 1; cross_a[8] = 1; cross_a[10] = 1;
    run_shot(3, 5, 6, 0, 0, 0);
    chk("R3 directed tof literal", res_tof, 7);
    chk("R6 directed peaks literal", res_peaks, 2);

    // R5 no echo: crossings only in blanking, envelope high in window
    clear_arrays();
    for (int t = 1; t <= 4; t++) cross_a[t] = 1;
    for (int t = 5; t <= 20; t++) env_a[t] = 1;
    run_shot(4, 6, 10, 1, 0, 1);
    chk("R5 no echo literal", res_no_echo, 1);

    // R2 blanking swallows the whole window
    for (int t = 0; t < 256; t++) begin env_a[t] = 1; cross_a[t] = 1; end
    run_shot(20, 5, 10, 0, 0, 1);
    chk("R2 blanked window has no stray", res_oow_hits, 0);

    // R11 saturation of hits and peaks
    run_shot(0, 2, 40, 1, 0, 1);
    for (int t = 0; t < 256; t++) begin env_a[t] = t[0]; cross_a[t] = 0; end
    run_shot(0, 1, 60, 0, 0, 1);
    chk("R11 peak saturation literal", res_peaks, CMAX);

    // R9 overrun mid-shot
    chk("R9 overrun clear before", overrun, 0);
    fill_random();
    run_shot(2, 4, 12, 1, 6, 1);
    chk("R9 overrun set", overrun, 1);
    // R9 strobe in the closing cycle (relative cycle 15 for window end 16)
    fill_random();
    run_shot(1, 3, 13, 0, 15, 1);
    nd = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) nd++;
    end
    chk("R9 closing-cycle strobe ignored", nd, 0);
    chk("R9 overrun sticky", overrun, 1);

    // random shots, alternating direction, shared time base
    for (int s = 0; s < 60; s++) begin
      fill_random();
      run_shot($urandom % 16, $urandom % 30, $urandom % 30, s[0], 0, 1);
      repeat ($urandom % 5) @(negedge clk);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule